// File: doc/BRIEF.md
# Trap return state restorer

This block carries out the two trap-return commands of a processor that keeps a small stack of saved trap frames, one per trap level. Each frame holds the trapped program counter, the trapped next program counter and a 40-bit saved-state word. The trap-entry side pushes frames through a simple write port, and each push raises the trap level `tl` by one. A return command then reads the frame at the current level and restores from it, in one update, the program counter pair, the condition codes, the address-space identifier, the processor-state word and the current window pointer. It then lowers `tl` by one.

The two commands differ only in how the counter pair is rebuilt: the done form resumes after the trapped instruction, and the retry form re-executes it. Three bits of the restored processor-state word choose which of four banks of eight global registers is live. When that choice changes, the live globals are written back into the old bank and the new bank's contents become live, all in the same cycle. A completed return pulses a recheck request for the interrupt logic. A return issued with no saved frame raises an illegal-instruction indication instead and changes no state.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, `pc`, `npc`, `ccr`, `asi`, `pstate`, `cwp` and `tl` are all zero, `illegal_trap` and `irq_recheck` are low, `cmd_ready` is high, and every global register in every bank reads zero.
- R2: A push that is accepted (`push_valid` high, no command pending or in flight, `tl` below MAXTL) stores the frame at stack slot `tl` and increments `tl`. A push while `tl` equals MAXTL is ignored, and the frame at the top is left intact.
- R3: The done form (`cmd_retry`=0) sets `pc` to the saved next PC and `npc` to the saved next PC plus 4.
- R4: The retry form (`cmd_retry`=1) sets `pc` to the saved PC and `npc` to the saved next PC.
- R5: `ccr` takes saved-state bits 39:32, where the upper nibble holds the 64-bit flags and the lower nibble the 32-bit flags. `asi` takes bits 31:24.
- R6: `pstate` takes saved-state bits 19:8 ANDed with 0xF3F.
- R7: `cwp` becomes NWIN-1 minus (saved-state bits 7:0 modulo NWIN), because the saved field counts windows in the opposite direction.
- R8: Each completed return lowers `tl` by one, so nested returns consume frames from the newest to the oldest.
- R9: The bank is chosen by pstate bits {11,10,0}: 000 selects normal, 001 alternate, 010 MMU and 100 interrupt. When a return changes the selected bank, the live globals are saved into the old bank and the new bank is loaded into the live set.
- R10: Any other combination of the three select bits selects the normal bank. A return that keeps the same bank leaves the live globals untouched.
- R11: With parameter NO_ALT=1, pstate bit 0 is cleared before it is stored and before the bank is selected.
- R12: A command issued while `tl` is 0 pulses `illegal_trap` for one cycle and changes no other state.
- R13: A command is accepted when `cmd_ready` is high. Its results appear one cycle later, together with a one-cycle `irq_recheck` pulse. `cmd_ready` is low for that one cycle, and any command presented during it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push a trap frame at level `tl` |
| push_pc | input | AW | Trapped PC to save |
| push_npc | input | AW | Trapped next PC to save |
| push_tstate | input | 40 | Saved-state word |
| cmd_valid | input | 1 | Trap-return command request |
| cmd_retry | input | 1 | 1 selects the retry form, 0 the done form |
| cmd_ready | output | 1 | High when a command can be accepted |
| greg_we | input | 1 | Write a live global register |
| greg_waddr | input | 3 | Live global write index |
| greg_wdata | input | DW | Live global write data |
| greg_raddr | input | 3 | Live global read index |
| greg_rdata | output | DW | Registered live global read data |
| pc | output | AW | Restored program counter |
| npc | output | AW | Restored next program counter |
| ccr | output | 8 | Restored condition codes |
| asi | output | 8 | Restored address-space identifier |
| pstate | output | 12 | Restored processor state |
| cwp | output | CWPW | Current window pointer |
| tl | output | TLW | Current trap level |
| illegal_trap | output | 1 | One-cycle illegal-instruction pulse |
| irq_recheck | output | 1 | One-cycle interrupt recheck pulse |

## Verification
The main instance is built with NWIN=5 and MAXTL=3. Because 5 is not a power of two, the modulo fold of the 8-bit window field produces values that a plain bit truncation would get wrong, such as 7 mapping to window 2. With only three slots, the full stack and the ignored push are reached after three frames. A second instance with NO_ALT=1 receives the same stimulus, so the cleared alternate-select bit and its effect on bank choice can be compared side by side. The bank tests then cycle through all four banks and one unrecognised code, checking that each bank keeps its own contents.

// File: rtl/trpret_pkg.sv
package trpret_pkg;

  localparam int          PS_W    = 12;
  localparam int          TS_W    = 40;
  localparam logic [11:0] PS_KEEP = 12'hF3F;
  localparam logic [11:0] PS_ALT  = 12'h001;

  typedef enum logic [1:0] {
    GB_NORMAL = 2'd0,
    GB_ALT    = 2'd1,
    GB_MMU    = 2'd2,
    GB_IRQ    = 2'd3
  } gbank_e;

  // bank select decode on pstate bits {11,10,0}
  function automatic gbank_e bank_of(input logic [PS_W-1:0] ps);
    case ({ps[11], ps[10], ps[0]})
      3'b001:  return GB_ALT;
      3'b010:  return GB_MMU;
      3'b100:  return GB_IRQ;
      default: return GB_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/trpret_frame_ram.sv
module trpret_frame_ram #(
  parameter int DEPTH = 4,
  parameter int AW    = 64,
  parameter int TSW   = 40,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW    = 2 * AW + TSW
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [AW-1:0]    wpc,
  input  logic [AW-1:0]    wnpc,
  input  logic [TSW-1:0]   wts,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [AW-1:0]    rpc,
  output logic [AW-1:0]    rnpc,
  output logic [TSW-1:0]   rts
);

  logic [FW-1:0] mem [DEPTH];
  logic [FW-1:0] rd_q;

  // single write port, registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wpc, wnpc, wts};
    if (re) rd_q <= mem[raddr];
  end

  assign rpc  = rd_q[FW-1 -: AW];
  assign rnpc = rd_q[TSW +: AW];
  assign rts  = rd_q[TSW-1:0];

endmodule

// File: rtl/trpret_gbank.sv
module trpret_gbank
  import trpret_pkg::*;
#(
  parameter int DW   = 64,
  parameter int NREG = 8,
  localparam int RA_W = $clog2(NREG),
  localparam int NBANK = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            swap,
  input  gbank_e          old_bank,
  input  gbank_e          new_bank,
  input  logic            we,
  input  logic [RA_W-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic [RA_W-1:0] raddr,
  output logic [DW-1:0]   rdata
);

  logic [NREG*DW-1:0] live_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] live_r;
    logic [DW-1:0] bk [NBANK];

    always_ff @(posedge clk) begin
      if (rst) begin
        live_r <= '0;
      end else if (swap) begin
        live_r <= bk[new_bank];
      end else if (we && (waddr == RA_W'(i))) begin
        live_r <= wdata;
      end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) begin
          bk[b] <= '0;
        end else if (swap && (old_bank == gbank_e'(b))) begin
          bk[b] <= live_r;
        end
      end
    end

    assign live_flat[i*DW +: DW] = live_r;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= live_flat[raddr*DW +: DW];
  end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trpret_pkg::*;
#(
  parameter int AW     = 64,
  parameter int DW     = 64,
  parameter int NWIN   = 8,
  parameter int MAXTL  = 4,
  parameter bit NO_ALT = 1'b0,
  localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int TLW   = $clog2(MAXTL + 1),
  localparam int IDX_W = (MAXTL > 1) ? $clog2(MAXTL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  input  logic [AW-1:0]   push_pc,
  input  logic [AW-1:0]   push_npc,
  input  logic [TS_W-1:0] push_tstate,
  input  logic            cmd_valid,
  input  logic            cmd_retry,
  output logic            cmd_ready,
  input  logic            greg_we,
  input  logic [2:0]      greg_waddr,
  input  logic [DW-1:0]   greg_wdata,
  input  logic [2:0]      greg_raddr,
  output logic [DW-1:0]   greg_rdata,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   npc,
  output logic [7:0]      ccr,
  output logic [7:0]      asi,
  output logic [PS_W-1:0] pstate,
  output logic [CWPW-1:0] cwp,
  output logic [TLW-1:0]  tl,
  output logic            illegal_trap,
  output logic            irq_recheck
);

  localparam logic [7:0] NWIN_B = 8'(NWIN);

  logic            busy;
  logic            retry_q;
  logic            accept_cmd;
  logic            take_push;
  logic [AW-1:0]   f_pc;
  logic [AW-1:0]   f_npc;
  logic [TS_W-1:0] f_ts;
  logic [PS_W-1:0] ps_masked;
  logic [PS_W-1:0] ps_next;
  logic [7:0]      cwp_field;
  logic [7:0]      cwp_fold;
  logic [CWPW-1:0] cwp_next;
  gbank_e          bank_cur;
  gbank_e          bank_nxt;
  logic            do_swap;

  assign cmd_ready  = ~busy;
  assign accept_cmd = cmd_valid & ~busy;
  assign take_push  = push_valid & ~busy & ~cmd_valid & (tl < TLW'(MAXTL));

  trpret_frame_ram #(
    .DEPTH (MAXTL),
    .AW    (AW),
    .TSW   (TS_W)
  ) u_frames (
    .clk   (clk),
    .we    (take_push),
    .waddr (IDX_W'(tl)),
    .wpc   (push_pc),
    .wnpc  (push_npc),
    .wts   (push_tstate),
    .re    (accept_cmd),
    .raddr (IDX_W'(tl - 1'b1)),
    .rpc   (f_pc),
    .rnpc  (f_npc),
    .rts   (f_ts)
  );

  // processor-state masking, with optional removal of the alternate select
  assign ps_masked = f_ts[19:8] & PS_KEEP;
  if (NO_ALT) begin : g_noalt
    assign ps_next = ps_masked & ~PS_ALT;
  end else begin : g_alt
    assign ps_next = ps_masked;
  end

  // reversed window numbering folded into range
  assign cwp_field = f_ts[7:0];
  assign cwp_fold  = cwp_field % NWIN_B;
  assign cwp_next  = CWPW'(NWIN_B - 8'd1 - cwp_fold);

  assign bank_cur = bank_of(pstate);
  assign bank_nxt = bank_of(ps_next);
  assign do_swap  = busy & (bank_cur != bank_nxt);

  trpret_gbank #(
    .DW   (DW),
    .NREG (8)
  ) u_globals (
    .clk      (clk),
    .rst      (rst),
    .swap     (do_swap),
    .old_bank (bank_cur),
    .new_bank (bank_nxt),
    .we       (greg_we),
    .waddr    (greg_waddr),
    .wdata    (greg_wdata),
    .raddr    (greg_raddr),
    .rdata    (greg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      retry_q      <= 1'b0;
      pc           <= '0;
      npc          <= '0;
      ccr          <= '0;
      asi          <= '0;
      pstate       <= '0;
      cwp          <= '0;
      tl           <= '0;
      illegal_trap <= 1'b0;
      irq_recheck  <= 1'b0;
    end else begin
      illegal_trap <= 1'b0;
      irq_recheck  <= 1'b0;
      if (busy) begin
        pc          <= retry_q ? f_pc : f_npc;
        npc         <= retry_q ? f_npc : f_npc + AW'(4);
        ccr         <= f_ts[39:32];
        asi         <= f_ts[31:24];
        pstate      <= ps_next;
        cwp         <= cwp_next;
        tl          <= tl - 1'b1;
        busy        <= 1'b0;
        irq_recheck <= 1'b1;
      end else if (accept_cmd) begin
        if (tl == '0) begin
          illegal_trap <= 1'b1;
        end else begin
          busy    <= 1'b1;
          retry_q <= cmd_retry;
        end
      end else if (take_push) begin
        tl <= tl + 1'b1;
      end
    end
  end

endmodule

// File: rtl/trpret_checker.sv
module trpret_checker #(
  parameter int NWIN  = 8,
  parameter int MAXTL = 4,
  localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int TLW  = $clog2(MAXTL + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_ready,
  input logic            illegal_trap,
  input logic            irq_recheck,
  input logic [TLW-1:0]  tl,
  input logic [CWPW-1:0] cwp,
  input logic [11:0]     pstate,
  input logic [63:0]     pc
);

  p_tl_bound_r2: assert property (@(posedge clk) disable iff (rst)
    tl <= TLW'(MAXTL));

  p_pstate_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (pstate & 12'h0C0) == 12'h000);

  p_cwp_range_r7: assert property (@(posedge clk) disable iff (rst)
    cwp <= CWPW'(NWIN - 1));

  p_tl_step_r8: assert property (@(posedge clk) disable iff (rst)
    irq_recheck |-> tl == $past(tl) - 1'b1);

  p_illegal_level_r12: assert property (@(posedge clk) disable iff (rst)
    illegal_trap |-> (tl == '0) && $stable(tl) && $stable(pc) && $stable(pstate));

  p_recheck_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    irq_recheck |=> !irq_recheck);

  p_busy_once_r13: assert property (@(posedge clk) disable iff (rst)
    !cmd_ready |=> cmd_ready);

  p_no_overlap_r13: assert property (@(posedge clk) disable iff (rst)
    !(illegal_trap && irq_recheck));

endmodule

bind trap_return_unit trpret_checker #(
  .NWIN  (NWIN),
  .MAXTL (MAXTL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_ready    (cmd_ready),
  .illegal_trap (illegal_trap),
  .irq_recheck  (irq_recheck),
  .tl           (tl),
  .cwp          (cwp),
  .pstate       (pstate),
  .pc           (64'(pc))
);

// File: tb/trap_return_unit_tb.sv
module trap_return_unit_tb;

  localparam int NW = 5;
  localparam int MT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 1'b0;
  logic [63:0] push_pc = '0;
  logic [63:0] push_npc = '0;
  logic [39:0] push_tstate = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_retry = 1'b0;
  logic        greg_we = 1'b0;
  logic [2:0]  greg_waddr = '0;
  logic [63:0] greg_wdata = '0;
  logic [2:0]  greg_raddr = '0;

  logic        cmd_ready, illegal_trap, irq_recheck;
  logic [63:0] greg_rdata, pc, npc;
  logic [7:0]  ccr, asi;
  logic [11:0] pstate;
  logic [2:0]  cwp;
  logic [1:0]  tl;

  logic        na_ready, na_illegal, na_recheck;
  logic [63:0] na_rdata, na_pc, na_npc;
  logic [7:0]  na_ccr, na_asi;
  logic [11:0] na_pstate;
  logic [2:0]  na_cwp;
  logic [1:0]  na_tl;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  trap_return_unit #(.AW(64), .DW(64), .NWIN(NW), .MAXTL(MT), .NO_ALT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_pc(push_pc),
    .push_npc(push_npc), .push_tstate(push_tstate), .cmd_valid(cmd_valid),
    .cmd_retry(cmd_retry), .cmd_ready(cmd_ready), .greg_we(greg_we),
    .greg_waddr(greg_waddr), .greg_wdata(greg_wdata), .greg_raddr(greg_raddr),
    .greg_rdata(greg_rdata), .pc(pc), .npc(npc), .ccr(ccr), .asi(asi),
    .pstate(pstate), .cwp(cwp), .tl(tl), .illegal_trap(illegal_trap),
    .irq_recheck(irq_recheck));

  trap_return_unit #(.AW(64), .DW(64), .NWIN(NW), .MAXTL(MT), .NO_ALT(1'b1)) u_dut_na (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_pc(push_pc),
    .push_npc(push_npc), .push_tstate(push_tstate), .cmd_valid(cmd_valid),
    .cmd_retry(cmd_retry), .cmd_ready(na_ready), .greg_we(greg_we),
    .greg_waddr(greg_waddr), .greg_wdata(greg_wdata), .greg_raddr(greg_raddr),
    .greg_rdata(na_rdata), .pc(na_pc), .npc(na_npc), .ccr(na_ccr), .asi(na_asi),
    .pstate(na_pstate), .cwp(na_cwp), .tl(na_tl), .illegal_trap(na_illegal),
    .irq_recheck(na_recheck));

  function automatic logic [39:0] mk_ts(input logic [7:0] c, input logic [7:0] a,
                                        input logic [11:0] ps, input logic [7:0] w);
    return {c, a, 4'h0, ps, w};
  endfunction

  function automatic logic [63:0] exp_cwp(input logic [7:0] w);
    return 64'(NW - 1 - (int'(w) % NW));
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic push(input logic [63:0] p, input logic [63:0] n, input logic [39:0] ts);
    @(negedge clk);
    push_valid = 1'b1; push_pc = p; push_npc = n; push_tstate = ts;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  // returns with outputs updated at the sampling negedge
  task automatic ret(input bit retry);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_retry = retry;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic gwrite(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    greg_we = 1'b1; greg_waddr = a; greg_wdata = d;
    @(negedge clk);
    greg_we = 1'b0;
  endtask

  task automatic gread(input logic [2:0] a, output logic [63:0] d, output logic [63:0] dn);
    @(negedge clk);
    greg_raddr = a;
    @(negedge clk);
    d = greg_rdata;
    dn = na_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] d, dn;
    chk("R1", "pc", pc, 0);
    chk("R1", "npc", npc, 0);
    chk("R1", "ccr", 64'(ccr), 0);
    chk("R1", "asi", 64'(asi), 0);
    chk("R1", "pstate", 64'(pstate), 0);
    chk("R1", "cwp", 64'(cwp), 0);
    chk("R1", "tl", 64'(tl), 0);
    chk("R1", "flags", {61'd0, illegal_trap, irq_recheck, cmd_ready}, 64'd1);
    gread(3'd3, d, dn);
    chk("R1", "global g3", d, 0);
  endtask

  task automatic t_illegal(input logic [63:0] pc_exp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_retry = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R12", "illegal pulse", 64'(illegal_trap), 1);
    chk("R12", "no recheck", 64'(irq_recheck), 0);
    @(negedge clk);
    chk("R12", "illegal one cycle", 64'(illegal_trap), 0);
    chk("R12", "tl held", 64'(tl), 0);
    chk("R12", "pc held", pc, pc_exp);
  endtask

  task automatic t_fill;
    logic [63:0] d, dn;
    gwrite(3'd3, 64'h33);
    gread(3'd3, d, dn);
    chk("R9", "normal g3 written", d, 64'h33);
    push(64'h1000, 64'h1004, mk_ts(8'h0F, 8'hFF, 12'h400, 8'd3));
    chk("R2", "tl after push1", 64'(tl), 1);
    push(64'h2000, 64'h2010, mk_ts(8'hC3, 8'h22, 12'h001, 8'd0));
    chk("R2", "tl after push2", 64'(tl), 2);
    push(64'h3000, 64'h3008, mk_ts(8'h5A, 8'h11, 12'hFFF, 8'd7));
    chk("R2", "tl after push3", 64'(tl), 3);
    push(64'hDEAD, 64'hBEEF, mk_ts(8'hEE, 8'hEE, 12'h800, 8'd1));
    chk("R2", "full push ignored", 64'(tl), 3);
  endtask

  task automatic t_retry_top;
    logic [63:0] d, dn;
    ret(1'b1);
    chk("R13", "recheck pulse", 64'(irq_recheck), 1);
    chk("R4", "retry pc", pc, 64'h3000);
    chk("R4", "retry npc", npc, 64'h3008);
    chk("R5", "ccr", 64'(ccr), 64'h5A);
    chk("R5", "asi", 64'(asi), 64'h11);
    chk("R6", "pstate mask", 64'(pstate), 64'hF3F);
    chk("R7", "cwp fold 7", 64'(cwp), exp_cwp(8'd7));
    chk("R8", "tl", 64'(tl), 2);
    chk("R11", "noalt pstate", 64'(na_pstate), 64'hF3E);
    @(negedge clk);
    chk("R13", "recheck one cycle", 64'(irq_recheck), 0);
    gread(3'd3, d, dn);
    chk("R10", "unrecognised keeps normal", d, 64'h33);
  endtask

  task automatic t_done_hold;
    logic [63:0] d, dn;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_retry = 1'b0;
    @(negedge clk);
    chk("R13", "ready low while busy", 64'(cmd_ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R3", "done pc", pc, 64'h2010);
    chk("R3", "done npc", npc, 64'h2014);
    chk("R5", "ccr flags", 64'(ccr), 64'hC3);
    chk("R7", "cwp fold 0", 64'(cwp), exp_cwp(8'd0));
    chk("R13", "held command ignored", 64'(tl), 1);
    chk("R11", "noalt clears bit0", 64'(na_pstate), 64'h000);
    chk("R6", "alt pstate", 64'(pstate), 64'h001);
    @(negedge clk);
    chk("R13", "still one return", 64'(tl), 1);
    gread(3'd3, d, dn);
    chk("R9", "alt bank loaded", d, 64'h0);
    chk("R11", "noalt stays normal", dn, 64'h33);
    gwrite(3'd3, 64'h44);
  endtask

  task automatic t_last;
    logic [63:0] d, dn;
    ret(1'b1);
    chk("R4", "retry pc L1", pc, 64'h1000);
    chk("R4", "retry npc L1", npc, 64'h1004);
    chk("R5", "asi L1", 64'(asi), 64'hFF);
    chk("R7", "cwp fold 3", 64'(cwp), exp_cwp(8'd3));
    chk("R8", "tl empty", 64'(tl), 0);
    gread(3'd3, d, dn);
    chk("R9", "mmu bank loaded", d, 64'h0);
    gwrite(3'd3, 64'h55);
  endtask

  task automatic t_bank(input logic [11:0] ps, input logic [7:0] w, input bit retry,
                        input logic [63:0] exp_g3, input string req);
    logic [63:0] d, dn;
    push(64'h4000, 64'h4004, mk_ts(8'h00, 8'h00, ps, w));
    ret(retry);
    chk(req, "pstate", 64'(pstate), 64'(ps & 12'hF3F));
    chk("R7", "cwp", 64'(cwp), exp_cwp(w));
    chk(retry ? "R4" : "R3", "pc", pc, retry ? 64'h4000 : 64'h4004);
    gread(3'd3, d, dn);
    chk(req, "g3 after swap", d, exp_g3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_illegal(64'h0);
    t_fill();
    t_retry_top();
    t_done_hold();
    t_last();
    t_illegal(64'h1000);
    t_bank(12'h000, 8'd255, 1'b0, 64'h33, "R9");
    t_bank(12'h001, 8'd9,   1'b1, 64'h44, "R9");
    t_bank(12'h800, 8'd4,   1'b0, 64'h00, "R9");
    t_bank(12'h400, 8'd12,  1'b1, 64'h55, "R9");
    t_bank(12'hC01, 8'd1,   1'b0, 64'h33, "R10");
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule